// File: doc/BRIEF.md
# Boot-Strap Clock Source Selector

This block reads three mode-strap pins while reset is held and uses them to choose two derived clocks. It produces the system clock, which is the main input clock either undivided or divided by two. It also produces a low-speed reference clock, which has three possible sources: a dedicated 32.768 kHz input, the main input divided by 1024, or the main input divided by 2048. Everything runs in the main-input clock domain. A derived clock is presented in two forms. One is a one-cycle enable pulse on each of its rising edges. The other, for the reference clock, is a 50 % duty level.

Bit 1 of the straps chooses the system-clock ratio. Bits 2 and 1 together choose the reference source. Bit 0 only records whether the main source is a crystal or an external oscillator, and it changes no clock. The straps are captured on every clock edge while reset is low. Once reset is released they are frozen, and the captured 3-bit mode is reported on a port.

Top module: `clk_strap_select`

## Requirements
- R1: While `rst_n` is low, `mode_o` takes the value of `strap_i` on every clock edge, with bit order {bit2, bit1, bit0}. After release it holds the value captured at the last reset edge.
- R2: With strap bit 1 clear, `sys_en_o` is high in every cycle from the first cycle after reset release.
- R3: With strap bit 1 set, `sys_en_o` is high only in odd cycles after release (1, 3, 5, ...), where cycle k follows the k-th clock edge after release.
- R4: With strap bit 2 clear, `ref_clk_o` equals `ref32k_i` delayed by one clock. `ref_en_o` is high in the cycle where that delayed copy first shows 1.
- R5: With strap bits 2:1 = 10, `ref_clk_o` is high exactly in cycles whose count mod 1024 lies in 512..1023. `ref_en_o` is high only at count mod 1024 = 512.
- R6: With strap bits 2:1 = 11, the reference is the divide-by-2 clock divided again by 1024. `ref_clk_o` is high exactly in cycles whose count mod 2048 lies in 1024..2047. `ref_en_o` is high only at count mod 2048 = 1024.
- R7: Strap bit 0 changes none of `sys_en_o`, `ref_clk_o` or `ref_en_o`.
- R8: While reset is low, `sys_en_o`, `ref_clk_o` and `ref_en_o` are all 0.
- R9: Changes on `strap_i` after release affect neither `mode_o` nor any clock output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main input clock |
| rst_n | input | 1 | Synchronous active-low reset; straps are captured while it is low |
| strap_i | input | 3 | Mode strap pins |
| ref32k_i | input | 1 | Dedicated 32.768 kHz reference level, already in the `clk` domain |
| sys_en_o | output | 1 | System clock enable pulse |
| ref_clk_o | output | 1 | Selected reference clock level |
| ref_en_o | output | 1 | Reference clock rising-edge pulse |
| mode_o | output | 3 | Captured clock mode index |

## Verification
A mode captured wrongly shows up on `mode_o` in the first cycle after release, and in the wrong ratio on `sys_en_o` within two cycles. An off-by-one in a divider counter is invisible until the first reference edge. That edge is due at cycle 512 or 1024, and at that point the level and pulse land one cycle early or late. Each cycle is therefore compared against a cycle-count model for every mode. The bench also keeps toggling the straps after release, to expose any capture path that stays open.

// File: rtl/clk_strap_pkg.sv
// Shared types for the strap clock selector: reference source encoding
// and the decoded form of a captured mode.
package clk_strap_pkg;

    typedef enum logic [1:0] {
        REF_EXT32K = 2'd0,
        REF_DIV1K  = 2'd1,
        REF_DIV2K  = 2'd2
    } ref_src_e;

    typedef struct packed {
        logic     sys_half;
        ref_src_e ref_src;
    } clk_sel_t;

    // Turn a 3-bit mode into clock choices; bit 0 is deliberately unused.
    function automatic clk_sel_t decode_mode(input logic [2:0] m);
        clk_sel_t s;
        s.sys_half = m[1];
        if (!m[2])
            s.ref_src = REF_EXT32K;
        else if (!m[1])
            s.ref_src = REF_DIV1K;
        else
            s.ref_src = REF_DIV2K;
        return s;
    endfunction

endpackage

// File: rtl/strap_mode_latch.sv
// Captures the mode straps while reset is low and holds them afterwards.
// Assumes the straps are stable and synchronous to clk during reset.
module strap_mode_latch #(
    parameter int unsigned MODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] strap_i,
    output logic [MODE_W-1:0] mode_o
);

    logic [MODE_W-1:0] mode_q;

    // Track the straps during reset, freeze once reset is released.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= strap_i;
    end

    assign mode_o = mode_q;

    AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(mode_q)); // R9

endmodule

// File: rtl/clk_even_div.sv
// Even divider driven by an input tick enable. It toggles its level every
// HALF ticks, which gives 50 % duty, and flags in rise_o the cycle in which
// the level has just become 1. The counter clears on reset, so the first
// rising edge comes HALF ticks after release.
module clk_even_div #(
    parameter int unsigned HALF = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    output logic lvl_o,
    output logic rise_o
);

    localparam int unsigned CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic [CW-1:0] cnt_q;
    logic          lvl_q;
    logic          rise_q;
    logic          wrap;

    assign wrap = tick_i && (cnt_q == LAST);

    // Count ticks, flip the level at each wrap and mark rising flips.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            lvl_q  <= 1'b0;
            rise_q <= 1'b0;
        end else begin
            rise_q <= wrap && !lvl_q;
            if (tick_i)
                cnt_q <= wrap ? '0 : cnt_q + 1'b1;
            if (wrap)
                lvl_q <= ~lvl_q;
        end
    end

    assign lvl_o  = lvl_q;
    assign rise_o = rise_q;

    AST_LEVEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> $stable(lvl_q)); // R5

    AST_RISE_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        rise_q |-> (lvl_q && !$past(lvl_q))); // R6

endmodule

// File: rtl/clk_strap_select.sv
// Strap-driven clock source selector. It captures the mode during reset
// and derives the system enable (x1 or /2) and the reference clock
// (external 32.768 kHz, /1024, or /2 then /1024) in the clk domain.
// Assumes ref32k_i is already synchronous to clk.
module clk_strap_select #(
    parameter int unsigned REF_DIV = 1024
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] strap_i,
    input  logic       ref32k_i,
    output logic       sys_en_o,
    output logic       ref_clk_o,
    output logic       ref_en_o,
    output logic [2:0] mode_o
);
    import clk_strap_pkg::*;

    localparam int unsigned REF_HALF = REF_DIV / 2;

    logic [2:0] mode;
    clk_sel_t   sel;
    logic       run_q;
    logic       ext_q, ext_d;
    logic       h2_lvl, h2_rise;
    logic       k1_lvl, k1_rise;
    logic       k2_lvl, k2_rise;

    strap_mode_latch #(.MODE_W(3)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .strap_i (strap_i),
        .mode_o  (mode)
    );

    assign sel = decode_mode(mode);

    // Divide-by-2 of the main input.
    clk_even_div #(.HALF(1)) u_div2 (
        .clk(clk), .rst_n(rst_n), .tick_i(1'b1),
        .lvl_o(h2_lvl), .rise_o(h2_rise)
    );

    // Main input divided by REF_DIV.
    clk_even_div #(.HALF(REF_HALF)) u_div1k (
        .clk(clk), .rst_n(rst_n), .tick_i(1'b1),
        .lvl_o(k1_lvl), .rise_o(k1_rise)
    );

    // Divide-by-2 clock divided again by REF_DIV.
    clk_even_div #(.HALF(REF_HALF)) u_div2k (
        .clk(clk), .rst_n(rst_n), .tick_i(h2_rise),
        .lvl_o(k2_lvl), .rise_o(k2_rise)
    );

    // Undivided system enable: stays on from the first cycle after release.
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_q <= 1'b0;
        else
            run_q <= 1'b1;
    end

    // Register the external reference twice for level and edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_q <= 1'b0;
            ext_d <= 1'b0;
        end else begin
            ext_q <= ref32k_i;
            ext_d <= ext_q;
        end
    end

    assign sys_en_o = sel.sys_half ? h2_rise : run_q;

    // Pick the reference source according to the decoded mode.
    always_comb begin
        unique case (sel.ref_src)
            REF_DIV1K: begin ref_clk_o = k1_lvl; ref_en_o = k1_rise;        end
            REF_DIV2K: begin ref_clk_o = k2_lvl; ref_en_o = k2_rise;        end
            default:   begin ref_clk_o = ext_q;  ref_en_o = ext_q & ~ext_d; end
        endcase
    end

    assign mode_o = mode;

    AST_SYS_HALF_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (mode[1] && sys_en_o) |=> !sys_en_o); // R3

    AST_SYS_FULL_RATE: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode[1] && $past(rst_n)) |-> sys_en_o); // R2

    AST_REF_EN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ref_en_o |-> ref_clk_o); // R4

    AST_RESET_QUIET: assert property (@(posedge clk)
        (!rst_n && !$isunknown(mode)) |=> (!rst_n |-> (!sys_en_o && !ref_en_o))); // R8

endmodule

// File: tb/test_clk_strap_select.sv
// Bench: all eight modes plus random extra ones. The external reference is
// driven as a random square wave and the straps are randomised after
// release. Every cycle is compared against a cycle-count model.
module test_clk_strap_select;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] strap_i = 3'd0;
    logic       ref32k_i = 1'b0;
    logic       sys_en_o, ref_clk_o, ref_en_o;
    logic [2:0] mode_o;

    int checks = 0;
    int fails  = 0;
    logic h1, h2;

    always #5 clk = ~clk;

    clk_strap_select i_clk_strap_select (
        .clk(clk), .rst_n(rst_n), .strap_i(strap_i), .ref32k_i(ref32k_i),
        .sys_en_o(sys_en_o), .ref_clk_o(ref_clk_o), .ref_en_o(ref_en_o),
        .mode_o(mode_o)
    );

    function automatic logic exp_sys(input logic [2:0] m, input int c);
        return m[1] ? ((c % 2) == 1) : 1'b1;
    endfunction

    function automatic logic exp_lvl(input logic [2:0] m, input int c, input logic e1);
        if (!m[2]) return e1;
        if (!m[1]) return ((c / 512) % 2) == 1;
        return ((c / 1024) % 2) == 1;
    endfunction

    function automatic logic exp_en(input logic [2:0] m, input int c, input logic e1, input logic e2);
        if (!m[2]) return e1 && !e2;
        if (!m[1]) return (c % 1024) == 512;
        return (c % 2048) == 1024;
    endfunction

    function automatic string ref_tag(input logic [2:0] m);
        if (!m[2]) return m[0] ? "R4/R7" : "R4";
        if (!m[1]) return m[0] ? "R5/R7" : "R5";
        return m[0] ? "R6/R7" : "R6";
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
        end
    endtask

    task automatic run_mode(input logic [2:0] m, input int ncyc);
        int half_left = 1;
        rst_n = 1'b0;
        strap_i = m;
        ref32k_i = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R8 sys_en in reset", sys_en_o, 0);
        chk("R8 ref_en in reset", ref_en_o, 0);
        chk("R8 ref_clk in reset", ref_clk_o, 0);
        chk("R1 mode tracks straps in reset", mode_o, m);
        rst_n = 1'b1;
        h1 = 1'b0;
        h2 = 1'b0;
        for (int c = 1; c <= ncyc; c++) begin
            @(posedge clk);
            @(negedge clk);
            h2 = h1;
            h1 = ref32k_i;
            chk(m[1] ? "R3 sys_en" : "R2 sys_en", sys_en_o, exp_sys(m, c));
            chk({ref_tag(m), " ref_clk"}, ref_clk_o, exp_lvl(m, c, h1));
            chk({ref_tag(m), " ref_en"}, ref_en_o, exp_en(m, c, h1, h2));
            chk("R9 mode held", mode_o, m);
            strap_i = 3'($urandom_range(0, 7));
            half_left--;
            if (half_left == 0) begin
                ref32k_i = ~ref32k_i;
                half_left = $urandom_range(1, 6);
            end
        end
    endtask

    initial begin
        void'($urandom(32'h5EED));
        for (int m = 0; m < 8; m++)
            run_mode(3'(m), 4200);
        for (int k = 0; k < 2; k++)
            run_mode(3'($urandom_range(0, 7)), 1200);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 10);
        checks++;
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule